// File: doc/BRIEF.md
# Fracturable Lookup Table Cell

This block is a configurable logic cell of the kind found in a programmable fabric. It owns exactly 32 table bits. An elaboration-time parameter splits those bits into 1, 2, 4 or 8 equal sub-tables. Each sub-table reads its own private group of data pins. A select field then picks which sub-table's result reaches the single output. With one part, the cell is a plain 5-input table. With eight parts, it is eight 2-input tables behind an 8:1 multiplexer.

The table contents and one mode bit are loaded serially, one bit per clock, while the configuration enable is high. The mode bit chooses how the output is driven. In one setting the output follows the table look-up combinationally. In the other it comes from a flip-flop that samples the look-up on each clock edge where configuration is idle. A synchronous active-low reset clears the table, the mode bit and the flip-flop.

Top module: `frag_lut_cell`

## Requirements
- R1: The parameter NUM_PARTS sets the number of sub-tables. Each sub-table has 5 − log2(NUM_PARTS) address pins, so `data_in` is NUM_PARTS·(5 − log2 NUM_PARTS) bits wide and `sel_in` is log2(NUM_PARTS) bits wide, with a minimum of 1. Any NUM_PARTS outside {1, 2, 4, 8} stops elaboration with an error.
- R2: While `rst_n` is low at a rising edge, every table bit, the mode bit and the output flip-flop are cleared, so `dout` reads 0 afterwards.
- R3: While `cfg_en` is high, each rising edge shifts `cfg_din` into a 33-bit chain. After 33 shifts, the first bit sent is address 0 of sub-table 0. Sub-table j address a sits at chain position j·2^(5−log2 NUM_PARTS)+a. The last (33rd) bit is the mode bit: 1 selects the registered output, 0 the combinational output.
- R4: While `cfg_en` is low, the table and mode bits keep their values whatever `cfg_din` does.
- R5: Sub-table j takes `data_in[j·K + i]` as address bit i, where K is its address width and bit 0 is the least significant address bit.
- R6: `sel_in` holding the value s routes sub-table s to the output. When NUM_PARTS is 1, `sel_in` is ignored.
- R7: In combinational mode, `dout` equals the addressed table bit of the selected sub-table in the same cycle.
- R8: In registered mode, `dout` takes the looked-up bit at each rising edge where `cfg_en` is low. While `cfg_en` is high, it holds its value.
- R9: Data pins belonging to sub-tables that are not selected have no effect on `dout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en | input | 1 | High: shift one configuration bit per clock |
| cfg_din | input | 1 | Serial configuration bit |
| data_in | input | NUM_PARTS·(5−log2 NUM_PARTS) | Private address pins of all sub-tables, sub-table 0 in the low bits |
| sel_in | input | max(1, log2 NUM_PARTS) | Sub-table select for the output multiplexer |
| dout | output | 1 | Cell output, combinational or registered per the mode bit |

## Verification
The bound checker watches several behaviours on every cycle. It checks that reset clears the chain and the output, and that the newest chain bit is the previous cycle's serial input. It checks that the chain is frozen while configuration is idle. It also checks `dout` against an independently computed look-up in both output modes, and that the registered output holds during shifting.

Some behaviours only the bench's scenarios can show. These are whole-table loading order, a full sweep of every select and address value, changes on unselected pins, and a reset in the middle of operation. The bench covers them with a behavioural model that is compared against `dout` on every clock. The elaboration error for an illegal part count cannot be exercised at run time; only the derived port widths are checked.

// File: rtl/frag_lut_pkg.sv
// Package: shared constants and helpers for the fracturable lookup cell.
// Assumes the table budget is a power of two given by its log2.
package frag_lut_pkg;

    // Output mode encoding held in the last chain bit.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // True when the part count is one of the supported splits.
    function automatic bit parts_legal(input int parts);
        return (parts == 1) || (parts == 2) || (parts == 4) || (parts == 8);
    endfunction

endpackage

// File: rtl/frag_cfg_chain.sv
// Module: serial configuration store.
// Shifts one bit per clock toward index 0 while shift_en is high, so the
// first bit sent ends at index 0 after LEN shifts. Synchronous active-low reset.
module frag_cfg_chain #(
    parameter int LEN = 33
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] bits_q
);

    // Clear on reset, shift in at the top while enabled, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (shift_en) begin
            bits_q <= {din, bits_q[LEN-1:1]};
        end
    end

endmodule

// File: rtl/frag_sub_lut.sv
// Module: one sub-table read port.
// Returns the table bit at the given address; address bit 0 is the LSB.
module frag_sub_lut #(
    parameter int ADDR_W = 3,
    localparam int DEPTH = 2 ** ADDR_W
) (
    input  logic [DEPTH-1:0]  table_bits,
    input  logic [ADDR_W-1:0] addr,
    output logic              y
);

    // Plain indexed read of the sub-table contents.
    always_comb begin
        y = table_bits[addr];
    end

endmodule

// File: rtl/frag_out_stage.sv
// Module: select multiplexer and optional output flip-flop.
// Assumes sel carries at least log2(PARTS) meaningful bits when PARTS > 1.
// The flip-flop samples only while hold is low; reg_mode picks the output.
module frag_out_stage #(
    parameter int PARTS      = 4,
    parameter int SEL_PORT_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hold,
    input  logic                  reg_mode,
    input  logic [PARTS-1:0]      part_y,
    input  logic [SEL_PORT_W-1:0] sel,
    output logic                  dout
);

    logic picked;
    logic flop_q;

    // Multiplexer variant chosen by the part count.
    generate
        if (PARTS == 1) begin : g_single
            // One table: the select pins are not consulted.
            always_comb begin
                picked = part_y[0] | (1'b0 & (^sel));
            end
        end else begin : g_multi
            // Several tables: the select value indexes the part outputs.
            always_comb begin
                picked = part_y[sel];
            end
        end
    endgenerate

    // Output flip-flop: cleared by reset, loads only while configuration is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flop_q <= 1'b0;
        end else if (!hold) begin
            flop_q <= picked;
        end
    end

    // Output source according to the mode bit.
    always_comb begin
        dout = reg_mode ? flop_q : picked;
    end

endmodule

// File: rtl/frag_lut_cell.sv
// Module: fracturable lookup table cell (top).
// Splits a fixed 2**BUDGET_LOG2 bit table into NUM_PARTS sub-tables with
// private address pins, picks one through sel_in, and optionally registers
// the result. Assumes NUM_PARTS is 1, 2, 4 or 8; other values are rejected.
module frag_lut_cell #(
    parameter int NUM_PARTS   = 4,
    parameter int BUDGET_LOG2 = 5,
    localparam int SEL_W      = $clog2(NUM_PARTS),
    localparam int SEL_PORT_W = (SEL_W > 0) ? SEL_W : 1,
    localparam int SUB_ADDR_W = BUDGET_LOG2 - SEL_W,
    localparam int DATA_W     = NUM_PARTS * SUB_ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_en,
    input  logic                  cfg_din,
    input  logic [DATA_W-1:0]     data_in,
    input  logic [SEL_PORT_W-1:0] sel_in,
    output logic                  dout
);

    localparam int SUB_DEPTH  = 2 ** SUB_ADDR_W;
    localparam int TABLE_BITS = 2 ** BUDGET_LOG2;
    localparam int CHAIN_LEN  = TABLE_BITS + 1;

    // Reject unsupported splits at elaboration.
    generate
        if (!frag_lut_pkg::parts_legal(NUM_PARTS)) begin : g_bad_parts
            $error("frag_lut_cell: NUM_PARTS must be 1, 2, 4 or 8");
        end
    endgenerate

    logic [CHAIN_LEN-1:0] chain_q;
    logic [NUM_PARTS-1:0] part_y;
    logic                 reg_mode;

    // Serial store of table bits plus the mode bit at the top.
    frag_cfg_chain #(
        .LEN (CHAIN_LEN)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .bits_q   (chain_q)
    );

    // Decode the mode bit into the output-source control.
    always_comb begin
        reg_mode = (frag_lut_pkg::out_mode_e'(chain_q[TABLE_BITS]) == frag_lut_pkg::OUT_REG);
    end

    // One read port per sub-table, each on its own slice of table and pins.
    generate
        for (genvar j = 0; j < NUM_PARTS; j++) begin : g_part
            frag_sub_lut #(
                .ADDR_W (SUB_ADDR_W)
            ) sub_i (
                .table_bits (chain_q[j*SUB_DEPTH +: SUB_DEPTH]),
                .addr       (data_in[j*SUB_ADDR_W +: SUB_ADDR_W]),
                .y          (part_y[j])
            );
        end
    endgenerate

    // Part select and optional register.
    frag_out_stage #(
        .PARTS      (NUM_PARTS),
        .SEL_PORT_W (SEL_PORT_W)
    ) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (cfg_en),
        .reg_mode (reg_mode),
        .part_y   (part_y),
        .sel      (sel_in),
        .dout     (dout)
    );

endmodule

// File: rtl/frag_lut_cell_chk.sv
// Module: assertion checker for frag_lut_cell, attached by bind.
// Computes its own look-up from the chain contents and the pins.
module frag_lut_cell_chk #(
    parameter int NUM_PARTS   = 4,
    parameter int BUDGET_LOG2 = 5,
    localparam int SEL_W      = $clog2(NUM_PARTS),
    localparam int SEL_PORT_W = (SEL_W > 0) ? SEL_W : 1,
    localparam int SUB_ADDR_W = BUDGET_LOG2 - SEL_W,
    localparam int DATA_W     = NUM_PARTS * SUB_ADDR_W,
    localparam int SUB_DEPTH  = 2 ** SUB_ADDR_W,
    localparam int CHAIN_LEN  = (2 ** BUDGET_LOG2) + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_en,
    input logic                  cfg_din,
    input logic [DATA_W-1:0]     data_in,
    input logic [SEL_PORT_W-1:0] sel_in,
    input logic                  dout,
    input logic [CHAIN_LEN-1:0]  cfg_q
);

    int                     sel_idx;
    logic [DATA_W-1:0]      shifted;
    logic [SUB_ADDR_W-1:0]  addr;
    logic [BUDGET_LOG2-1:0] flat;
    logic                   ref_bit;
    logic                   mode_bit;

    // Independent look-up: pick the part, slice its pins, index the table.
    always_comb begin
        sel_idx  = (NUM_PARTS == 1) ? 0 : int'(sel_in);
        shifted  = data_in >> (sel_idx * SUB_ADDR_W);
        addr     = shifted[SUB_ADDR_W-1:0];
        flat     = BUDGET_LOG2'(sel_idx * SUB_DEPTH) | BUDGET_LOG2'(addr);
        ref_bit  = cfg_q[flat];
        mode_bit = cfg_q[CHAIN_LEN-1];
    end

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dout == 1'b0) && (cfg_q == '0));

    // R3
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cfg_en) |=> (cfg_q[CHAIN_LEN-1] == $past(cfg_din)));

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cfg_en) |=> $stable(cfg_q));

    // R7
    comb_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bit == 1'b0) |-> (dout == ref_bit));

    // R8
    reg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !cfg_en && mode_bit) |=> (dout == $past(ref_bit)));

    // R8
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cfg_en && cfg_din && mode_bit) |=> $stable(dout));

endmodule

bind frag_lut_cell frag_lut_cell_chk #(
    .NUM_PARTS   (NUM_PARTS),
    .BUDGET_LOG2 (BUDGET_LOG2)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .data_in (data_in),
    .sel_in  (sel_in),
    .dout    (dout),
    .cfg_q   (chain_q)
);

// File: tb/frag_lut_cell_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural per-clock model of the cell, compared on every falling edge.
module frag_lut_cell_tb_top;

    localparam int PARTS  = 4;
    localparam int SELW   = 2;
    localparam int K      = 5 - SELW;
    localparam int DEPTH  = 1 << K;
    localparam int DATAW  = PARTS * K;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_en = 1'b0;
    logic             cfg_din = 1'b0;
    logic [DATAW-1:0] data_in = '0;
    logic [SELW-1:0]  sel_in = '0;
    logic             dout;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R2";

    bit m_cfg[$];
    bit m_q = 1'b0;

    frag_lut_cell #(.NUM_PARTS(PARTS)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .data_in (data_in),
        .sel_in  (sel_in),
        .dout    (dout)
    );

    always #2 clk = ~clk;

    // Model look-up from integer arithmetic on the pins.
    function automatic bit model_look();
        int part;
        int addr;
        part = int'(sel_in);
        addr = int'((data_in >> (part * K)) & DATAW'(DEPTH - 1));
        return m_cfg[part * DEPTH + addr];
    endfunction

    // Model state update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cfg[i]) m_cfg[i] = 1'b0;
            m_q = 1'b0;
        end else if (cfg_en) begin
            void'(m_cfg.pop_front());
            m_cfg.push_back(cfg_din);
        end else begin
            m_q = model_look();
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            logic exp_v;
            exp_v = m_cfg[32] ? m_q : model_look();
            n_cmp++;
            if (dout !== exp_v) begin
                n_bad++;
                $display("FAIL %s: dout=%b expected=%b at %0t", cur_req, dout, exp_v, $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Shift a full table and mode bit, sub-table 0 address 0 first.
    task automatic load(input logic [31:0] tbl, input logic mode);
        cfg_en = 1'b1;
        for (int i = 0; i < 32; i++) begin
            cfg_din = tbl[i];
            tick();
        end
        cfg_din = mode;
        tick();
        cfg_en = 1'b0;
        cfg_din = 1'b0;
    endtask

    // Visit every select and address value with random unselected pins.
    task automatic sweep();
        for (int s = 0; s < PARTS; s++) begin
            for (int a = 0; a < DEPTH; a++) begin
                data_in = DATAW'($urandom);
                data_in[s*K +: K] = K'(a);
                sel_in = SELW'(s);
                tick();
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 33; i++) m_cfg.push_back(1'b0);
        tick();
        tick();
        cmp_on = 1'b1;
        // R1: derived port widths
        n_cmp++;
        if ($bits(dut_i.data_in) != 12 || $bits(dut_i.sel_in) != 2) begin
            n_bad++;
            $display("FAIL R1: widths %0d/%0d expected 12/2", $bits(dut_i.data_in), $bits(dut_i.sel_in));
        end
        // R2: reset state
        tick();
        rst_n = 1'b1;
        tick();
        // R3 R5 R6 R7: combinational mode with two table patterns
        cur_req = "R3/R5/R6/R7";
        load(32'hA5C3_1E96, 1'b0);
        sweep();
        load(32'h0F33_55FF, 1'b0);
        sweep();
        // R9: fixed select, other parts' pins churned
        cur_req = "R9";
        for (int s = 0; s < PARTS; s++) begin
            sel_in = SELW'(s);
            data_in[s*K +: K] = K'(s + 2);
            for (int n = 0; n < 10; n++) begin
                logic [K-1:0] keep;
                keep = data_in[s*K +: K];
                data_in = DATAW'($urandom);
                data_in[s*K +: K] = keep;
                tick();
            end
        end
        // R8: registered mode
        cur_req = "R8";
        load(32'h6B2D_91F4, 1'b1);
        sweep();
        // R4: idle configuration ignores serial input
        cur_req = "R4";
        for (int n = 0; n < 16; n++) begin
            cfg_din = n[0];
            data_in = DATAW'($urandom);
            sel_in = SELW'($urandom);
            tick();
        end
        // R8: output held while shifting ones in registered mode
        cur_req = "R8 hold";
        cfg_en = 1'b1;
        cfg_din = 1'b1;
        for (int n = 0; n < 6; n++) begin
            data_in = DATAW'($urandom);
            sel_in = SELW'($urandom);
            tick();
        end
        cfg_en = 1'b0;
        sweep();
        // R2: reset in the middle of operation
        cur_req = "R2 mid";
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        sweep();
        cmp_on = 1'b0;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule